// File: doc/BRIEF.md
# Host-Side Byte Queue Port for an I2C Master

This block is the host-facing half of a small byte queue that sits between a register interface and the bus engine of an I2C master. A write strobe on the host data register pushes one byte into the queue. A read strobe pops one byte. Each host access is checked against the transfer state and the transfer direction. An access that does not fit raises a sticky error flag and leaves the queue untouched. Each accepted access also counts down a back-end residual byte counter. That counter is loaded when a command starts, and it has its own underflow error.

The bus side is driven by a separate sequencer through two simple byte handshakes. During a read transfer the sequencer pushes the bytes it received. During a write transfer it pops the bytes to send. The queue fill level is published after every clock. A one-cycle hint tells the sequencer that a host byte has just arrived and may be drained. An error-reset strobe empties the queue, clears the residual counter and clears all error flags.

Top module: `hfifo_port`

## Requirements
- R1: The queue holds DEPTH (default 8) bytes in arrival order. `fifoCount` shows the number of stored bytes one clock after each push or pop. When a host access and a bus access are accepted in the same cycle, `fifoCount` changes by the net amount.
- R2: A host write or read while `xferActive` is 0 sets `errInvalidCmd` and leaves the queue unchanged.
- R3: A host write while `xferRead`=1, or a host read while `xferRead`=0, during an active transfer sets `errInvalidCmd` and is ignored.
- R4: A host write to a full queue, or a host read from an empty queue, in the matching direction sets `errOverrun` when `pacingAllow`=0. With `pacingAllow`=1 the access is dropped and no flag is set.
- R5: Each accepted host access decrements `residual` by one. If `residual` is already 0, the access still moves its byte, `residual` stays 0 and `errBackendAccess` is set.
- R6: An accepted host read loads the popped byte into bits 7:0 of `hostRdData` with every other bit 0. The value holds until the next accepted host read.
- R7: `errReset` empties the queue, sets `residual` to 0 and clears all three error flags. It overrides every other input in that cycle.
- R8: `drainHint` is 1 for exactly the cycle after an accepted host write and 0 otherwise.
- R9: `busPushReady` is 1 only during an active read transfer with the queue not full. `busPopValid` is 1 only during an active write transfer with the queue not empty. `busPopData` shows the oldest stored byte.
- R10: Error flags are sticky. Only `errReset` or `rstN` clears them.
- R11: `residLoad` loads `residLen` into `residual` and takes precedence over a decrement in the same cycle. When both host strobes are high, only the write is considered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferActive | input | 1 | A transfer is in progress |
| xferRead | input | 1 | Transfer direction: 1 read from device, 0 write to device |
| pacingAllow | input | 1 | Drop full/empty host accesses silently |
| errReset | input | 1 | Error-reset strobe |
| residLoad | input | 1 | Load the back-end residual |
| residLen | input | RES_W | Value loaded into the residual |
| hostWrEn | input | 1 | Host write of the data register |
| hostWrData | input | 8 | Byte written by the host |
| hostRdEn | input | 1 | Host read of the data register |
| hostRdData | output | DATA_W | Data register read value |
| busPushValid | input | 1 | Sequencer offers a received byte |
| busPushData | input | 8 | Received byte |
| busPushReady | output | 1 | Queue accepts a bus-side byte |
| busPopValid | output | 1 | Queue offers a byte to send |
| busPopData | output | 8 | Oldest stored byte |
| busPopReady | input | 1 | Sequencer takes the offered byte |
| fifoCount | output | CNT_W | Number of stored bytes |
| residual | output | RES_W | Back-end residual byte count |
| errInvalidCmd | output | 1 | Sticky invalid-command error |
| errOverrun | output | 1 | Sticky overrun error |
| errBackendAccess | output | 1 | Sticky residual underflow error |
| drainHint | output | 1 | Host byte just accepted |

## Verification
Directed phases cover the main cases. One fills the queue to full and tries one more write, once with pacing and once without. One drains the queue while the host writes in the same cycles, which separates a net-count update from a last-writer-wins update. Another pushes bytes from the bus and pops them from the host past the residual. This shows that an underflowing access still moves its byte. The wrong-direction, idle and dual-strobe cases each show the rejection without any queue change. A long random phase mixes every input against a queue-based model and catches ordering and priority slips that the directed phases miss.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;
  // Strobes from the control to the storage, one cycle's worth
  typedef struct packed {
    logic hostPush;
    logic hostPop;
    logic busPush;
    logic busPop;
    logic clear;
  } fifo_strobe_t;
endpackage

// File: rtl/hfifo_ctrl.sv
module hfifo_ctrl
  import hfifo_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xferActive,
  input  logic             xferRead,
  input  logic             pacingAllow,
  input  logic             errReset,
  input  logic             residLoad,
  input  logic [RES_W-1:0] residLen,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  input  logic             busPushValid,
  input  logic             busPopReady,
  input  logic             full,
  input  logic             empty,
  output fifo_strobe_t     strobe,
  output logic             busPushReady,
  output logic             busPopValid,
  output logic [RES_W-1:0] residual,
  output logic             errInvalidCmd,
  output logic             errOverrun,
  output logic             errBackendAccess,
  output logic             drainHint
);
  logic wrDir, rdDir, wrReq, rdReq;
  logic badAccess, overrunHit, accepted;

  assign wrDir = xferActive & ~xferRead;
  assign rdDir = xferActive & xferRead;
  assign wrReq = hostWrEn;
  assign rdReq = hostRdEn & ~hostWrEn;  // write wins when both strobe

  assign badAccess  = (wrReq & ~wrDir) | (rdReq & ~rdDir);
  assign overrunHit = ((wrReq & wrDir & full) | (rdReq & rdDir & empty)) & ~pacingAllow;

  assign busPushReady = rdDir & ~full;
  assign busPopValid  = wrDir & ~empty;

  always_comb begin
    strobe.clear    = errReset;
    strobe.hostPush = ~errReset & wrReq & wrDir & ~full;
    strobe.hostPop  = ~errReset & rdReq & rdDir & ~empty;
    strobe.busPush  = ~errReset & busPushValid & busPushReady;
    strobe.busPop   = ~errReset & busPopReady & busPopValid;
  end

  assign accepted = strobe.hostPush | strobe.hostPop;

  always_ff @(posedge clk) begin
    if (!rstN || errReset) begin
      residual         <= '0;
      errInvalidCmd    <= 1'b0;
      errOverrun       <= 1'b0;
      errBackendAccess <= 1'b0;
      drainHint        <= 1'b0;
    end else begin
      drainHint <= strobe.hostPush;
      if (badAccess)  errInvalidCmd <= 1'b1;
      if (overrunHit) errOverrun    <= 1'b1;
      if (residLoad) begin
        residual <= residLen;
      end else if (accepted) begin
        if (residual == '0) errBackendAccess <= 1'b1;
        else                residual <= residual - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hfifo_store.sv
module hfifo_store
  import hfifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifo_strobe_t      strobe,
  input  logic [7:0]        hostWrData,
  input  logic [7:0]        busPushData,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              full,
  output logic              empty,
  output logic [7:0]        headData,
  output logic [DATA_W-1:0] hostRdData
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;
  logic [7:0]       pushByte;

  assign doPush   = strobe.hostPush | strobe.busPush;
  assign doPop    = strobe.hostPop | strobe.busPop;
  assign pushByte = strobe.hostPush ? hostWrData : busPushData;
  assign full     = (fifoCount == CNT_W'(DEPTH));
  assign empty    = (fifoCount == '0);
  assign headData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !strobe.clear) mem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (doPush) wrPtr <= ptrNext(wrPtr);
      if (doPop)  rdPtr <= ptrNext(rdPtr);
      fifoCount <= fifoCount + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               hostRdData <= '0;
    else if (strobe.hostPop) hostRdData <= DATA_W'(headData);
  end
endmodule

// File: rtl/hfifo_port.sv
module hfifo_port
  import hfifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  parameter int RES_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferActive,
  input  logic              xferRead,
  input  logic              pacingAllow,
  input  logic              errReset,
  input  logic              residLoad,
  input  logic [RES_W-1:0]  residLen,
  input  logic              hostWrEn,
  input  logic [7:0]        hostWrData,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              busPushValid,
  input  logic [7:0]        busPushData,
  output logic              busPushReady,
  output logic              busPopValid,
  output logic [7:0]        busPopData,
  input  logic              busPopReady,
  output logic [CNT_W-1:0]  fifoCount,
  output logic [RES_W-1:0]  residual,
  output logic              errInvalidCmd,
  output logic              errOverrun,
  output logic              errBackendAccess,
  output logic              drainHint
);
  fifo_strobe_t strobe;
  logic         full, empty;

  hfifo_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .xferActive(xferActive), .xferRead(xferRead),
    .pacingAllow(pacingAllow), .errReset(errReset), .residLoad(residLoad),
    .residLen(residLen), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .busPushValid(busPushValid), .busPopReady(busPopReady),
    .full(full), .empty(empty), .strobe(strobe),
    .busPushReady(busPushReady), .busPopValid(busPopValid),
    .residual(residual), .errInvalidCmd(errInvalidCmd),
    .errOverrun(errOverrun), .errBackendAccess(errBackendAccess),
    .drainHint(drainHint)
  );

  hfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrData(hostWrData),
    .busPushData(busPushData), .fifoCount(fifoCount), .full(full),
    .empty(empty), .headData(busPopData), .hostRdData(hostRdData)
  );
endmodule

// File: rtl/hfifo_port_chk.sv
module hfifo_port_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  parameter int RES_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferActive,
  input logic              xferRead,
  input logic              pacingAllow,
  input logic              errReset,
  input logic              residLoad,
  input logic [RES_W-1:0]  residLen,
  input logic              hostWrEn,
  input logic [7:0]        hostWrData,
  input logic              hostRdEn,
  input logic [DATA_W-1:0] hostRdData,
  input logic              busPushValid,
  input logic [7:0]        busPushData,
  input logic              busPushReady,
  input logic              busPopValid,
  input logic [7:0]        busPopData,
  input logic              busPopReady,
  input logic [CNT_W-1:0]  fifoCount,
  input logic [RES_W-1:0]  residual,
  input logic              errInvalidCmd,
  input logic              errOverrun,
  input logic              errBackendAccess,
  input logic              drainHint
);
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && !errReset) |=> $stable(fifoCount));

  p_idle_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !xferActive && !errReset) |=> errInvalidCmd);

  p_overrun_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && xferActive && !xferRead && fifoCount == CNT_W'(DEPTH)
     && !pacingAllow && !errReset) |=> errOverrun);

  p_rd_upper_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    hostRdData[DATA_W-1:8] == '0);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    errReset |=> (fifoCount == '0 && residual == '0 && !errOverrun));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && xferActive && !xferRead && fifoCount < CNT_W'(DEPTH)
     && !errReset) |=> drainHint);

  p_bus_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busPushReady && busPopValid));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errOverrun && !errReset) |=> errOverrun);
endmodule

bind hfifo_port hfifo_port_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .RES_W(RES_W)) u_chk (.*);

// File: tb/hfifo_port_bench.sv
module hfifo_port_bench;
  localparam int DEPTH = 8, DATA_W = 64, RES_W = 16, CNT_W = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic xferActive = 0, xferRead = 0, pacingAllow = 0, errReset = 0, residLoad = 0;
  logic [RES_W-1:0] residLen = '0;
  logic hostWrEn = 0, hostRdEn = 0, busPushValid = 0, busPopReady = 0;
  logic [7:0] hostWrData = '0, busPushData = '0;
  logic [DATA_W-1:0] hostRdData;
  logic busPushReady, busPopValid, errInvalidCmd, errOverrun, errBackendAccess, drainHint;
  logic [7:0] busPopData;
  logic [CNT_W-1:0] fifoCount;
  logic [RES_W-1:0] residual;

  int checks = 0, failures = 0;

  // reference model state
  byte unsigned q[$];
  int  mRes = 0;
  bit  mInv = 0, mOvr = 0, mBe = 0, mDrain = 0;
  longint unsigned mRd = 0;

  always #5 clk = ~clk;

  hfifo_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .RES_W(RES_W)) u_hfifo_port (.*);

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    bit wrDir = xferActive && !xferRead;
    bit rdDir = xferActive && xferRead;
    int n = q.size();
    bit wr = hostWrEn, rd = hostRdEn && !hostWrEn;
    bit hp, hpop, bp, bpop;
    if (errReset) begin
      q.delete(); mRes = 0; mInv = 0; mOvr = 0; mBe = 0; mDrain = 0;
      return;
    end
    if ((wr && !wrDir) || (rd && !rdDir)) mInv = 1;
    if (((wr && wrDir && n == DEPTH) || (rd && rdDir && n == 0)) && !pacingAllow) mOvr = 1;
    hp   = wr && wrDir && n < DEPTH;
    hpop = rd && rdDir && n > 0;
    bp   = busPushValid && rdDir && n < DEPTH;
    bpop = busPopReady && wrDir && n > 0;
    if (hpop) mRd = longint'(q.pop_front());
    if (bpop) void'(q.pop_front());
    if (hp) q.push_back(hostWrData);
    if (bp) q.push_back(busPushData);
    if (residLoad) mRes = int'(residLen);
    else if (hp || hpop) begin
      if (mRes == 0) mBe = 1; else mRes--;
    end
    mDrain = hp;
  endtask

  task automatic compare();
    bit wrDir = xferActive && !xferRead;
    bit rdDir = xferActive && xferRead;
    bit expPr = rdDir && q.size() < DEPTH;
    bit expPv = wrDir && q.size() > 0;
    check(fifoCount == CNT_W'(q.size()), "R1 count", fifoCount, q.size());
    check(errInvalidCmd == mInv, "R2 invalid flag", errInvalidCmd, mInv);
    check(errOverrun == mOvr, "R4 overrun flag", errOverrun, mOvr);
    check(errBackendAccess == mBe, "R5 backend flag", errBackendAccess, mBe);
    check(residual == RES_W'(mRes), "R5 residual", residual, mRes);
    check(hostRdData == mRd, "R6 read data", hostRdData, mRd);
    check(drainHint == mDrain, "R8 drain hint", drainHint, mDrain);
    check(busPushReady == expPr, "R9 push ready", busPushReady, expPr);
    check(busPopValid == expPv, "R9 pop valid", busPopValid, expPv);
    if (expPv) check(busPopData == q[0], "R9 pop data", busPopData, q[0]);
  endtask

  // one clock: model and compare after the edge, return at the falling edge
  task automatic cyc();
    @(posedge clk);
    model();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic idle();
    hostWrEn = 0; hostRdEn = 0; busPushValid = 0; busPopReady = 0;
    errReset = 0; residLoad = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state
    check(fifoCount == 0 && residual == 0, "R1 reset count", fifoCount, 0);
    check(!errInvalidCmd && !errOverrun && !errBackendAccess, "R10 reset flags", 0, 0);
    cyc();

    // R2: write with no transfer
    hostWrEn = 1; hostWrData = 8'h11; cyc(); idle(); cyc();
    check(errInvalidCmd == 1 && fifoCount == 0, "R2 idle write", errInvalidCmd, 1);

    // R7: error reset clears
    errReset = 1; cyc(); idle();
    check(fifoCount == 0 && residual == 0 && !errInvalidCmd, "R7 clear", errInvalidCmd, 0);

    // write transfer, fill to full with pacing
    xferActive = 1; xferRead = 0; residLoad = 1; residLen = 16'd10; cyc(); idle();
    pacingAllow = 1;
    for (int i = 0; i < 9; i++) begin
      hostWrEn = 1; hostWrData = 8'hA0 + 8'(i); cyc();
    end
    idle(); cyc();
    check(fifoCount == 8 && !errOverrun, "R4 paced full write", errOverrun, 0);
    pacingAllow = 0; hostWrEn = 1; hostWrData = 8'hEE; cyc(); idle(); cyc();
    check(errOverrun == 1, "R4 overrun", errOverrun, 1);
    check(errOverrun == 1, "R10 sticky overrun", errOverrun, 1);

    // R3: host read during write transfer
    hostRdEn = 1; cyc(); idle(); cyc();
    check(errInvalidCmd == 1 && fifoCount == 8, "R3 wrong direction", fifoCount, 8);

    // drain while writing: net count
    busPopReady = 1; cyc();
    for (int i = 0; i < 4; i++) begin
      hostWrEn = 1; hostWrData = 8'h50 + 8'(i); cyc();
    end
    hostWrEn = 0;
    repeat (10) cyc();
    idle(); cyc();
    check(fifoCount == 0, "R1 drained", fifoCount, 0);

    // read transfer, residual underflow
    errReset = 1; cyc(); idle();
    xferRead = 1; residLoad = 1; residLen = 16'd3; cyc(); idle();
    for (int i = 0; i < 5; i++) begin
      busPushValid = 1; busPushData = 8'hC0 + 8'(i); cyc();
    end
    idle();
    for (int i = 0; i < 4; i++) begin
      hostRdEn = 1; cyc();
    end
    idle(); cyc();
    check(errBackendAccess == 1 && fifoCount == 1, "R5 underflow still pops", fifoCount, 1);
    check(hostRdData == 64'hC3, "R6 last byte", hostRdData, 64'hC3);

    // R11: both strobes high in a read transfer -> write considered only
    hostWrEn = 1; hostRdEn = 1; cyc(); idle(); cyc();
    check(fifoCount == 1 && hostRdData == 64'hC3, "R11 dual strobe", fifoCount, 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      xferActive   = ($urandom % 8) != 0;
      if ($urandom % 16 == 0) xferRead = ~xferRead;
      pacingAllow  = ($urandom % 4) == 0;
      errReset     = ($urandom % 60) == 0;
      residLoad    = ($urandom % 25) == 0;
      residLen     = RES_W'($urandom % 12);
      hostWrEn     = ($urandom % 3) == 0;
      hostRdEn     = ($urandom % 3) == 0;
      hostWrData   = 8'($urandom);
      busPushValid = ($urandom % 2) == 0;
      busPushData  = 8'($urandom);
      busPopReady  = ($urandom % 2) == 0;
      cyc();
    end
    idle(); cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule